// File: doc/BRIEF.md
# Address Translation Buffer with Table Walk

The block turns a 32-bit virtual word address into a physical word address. Pages are 4K words, so the low 12 bits of the address are the in-page offset and pass through untouched. The upper 20 bits, the virtual page number, are looked up in a small fully associative buffer. Each buffer slot holds a valid flag, a virtual page tag, a physical page number, a modified (dirty) flag and a recently-used (reference) flag.

On a hit, the physical address comes back in the cycle after the request is accepted. On a miss, the block reads a single page-table word from main memory and then fills a slot. That word sits at the table base register plus the virtual page number, with table entries stored one per word. If the fetched entry is not valid, the block raises a one-cycle fault pulse and leaves the buffer alone. Software loads the table base through a write strobe. A synchronous reset empties the buffer.

Top module: `addr_xlate_tlb`

## Requirements
- R1: On a hit, `rsp_valid` is high in the cycle after acceptance. `rsp_paddr` equals the slot's physical page number (upper 20 bits) joined to the request offset.
- R2: The low 12 bits of `rsp_paddr` always equal the low 12 bits of the accepted `req_addr`.
- R3: On a miss, `mem_req` rises in the cycle after acceptance and stays high until `mem_ack`. `mem_addr` is the table base plus the virtual page number, modulo 2^32. `req_ready` is low throughout.
- R4: A page-table word is 22 bits: bit 21 is valid, bit 20 is dirty, bits 19:0 are the physical page number. For a valid word, a slot is filled and `rsp_valid` is high in the cycle after the `mem_ack` cycle.
- R5: For a page-table word with bit 21 at 0, `fault` is high for exactly one cycle, in the cycle after `mem_ack`. No response is produced, and every slot, with its flags, is unchanged.
- R6: The slot to fill is chosen in this order: the lowest-numbered empty slot; if none, the lowest-numbered slot whose reference flag is 0; if none, slot 0.
- R7: Every hit or fill sets that slot's reference flag. If this leaves every valid slot with its reference flag set, the reference flags of all other slots are cleared.
- R8: A write sets the slot's dirty flag. A fill loads the dirty flag from the page-table word's dirty bit ORed with the write flag. `rsp_dirty` reports the slot's dirty flag after the access.
- R9: A cycle with `base_we` high loads `base_wdata` into the table base. Walks that start afterwards use the new base.
- R10: Synchronous reset empties every slot and clears the table base, `rsp_valid`, `fault` and `mem_req`. The block is ready afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| base_we | input | 1 | Table base load strobe |
| base_wdata | input | 32 | New table base (word address) |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Virtual word address |
| req_write | input | 1 | Request is a write |
| rsp_valid | output | 1 | Translation result valid (one cycle) |
| rsp_paddr | output | 32 | Physical word address |
| rsp_dirty | output | 1 | Slot dirty flag after the access |
| fault | output | 1 | Page fault pulse |
| mem_req | output | 1 | Page-table read request |
| mem_addr | output | 32 | Page-table word address |
| mem_ack | input | 1 | Read data valid, ends the request |
| mem_rdata | input | 22 | Page-table word |

## Verification
The hardest case to reach from the ports is the one where every slot is valid and each reference flag is set. There, the rule that clears all the other reference flags decides which slot is evicted next. The only port-visible sign of that choice is whether a later request hits or walks. The stimulus therefore fills all four slots with known pages and revisits them in chosen orders. It then runs a long pseudo-random stream over eight pages that keeps the buffer under eviction pressure, and a reference model predicts every hit or walk. A fault between fills, followed by hits on all resident pages, shows that the buffer was left intact.

// File: rtl/addr_xlate_tlb.sv
module addr_xlate_tlb #(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int PPN_W   = 20,
  parameter int ENTRIES = 4,
  parameter int PA_W    = PPN_W + OFF_W,
  parameter int PTE_W   = PPN_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_we,
  input  logic [PA_W-1:0]   base_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_addr,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_dirty,
  output logic              fault,
  output logic              mem_req,
  output logic [PA_W-1:0]   mem_addr,
  input  logic              mem_ack,
  input  logic [PTE_W-1:0]  mem_rdata
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int IW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int PV    = PTE_W - 1;
  localparam int PD    = PTE_W - 2;

  logic [ENTRIES-1:0] vld, rbit, dty;
  logic [VPN_W-1:0]   tag [ENTRIES];
  logic [PPN_W-1:0]   ppn [ENTRIES];
  logic [PA_W-1:0]    base;
  logic               walking, wr_q;
  logic [VPN_W-1:0]   vpn_q;
  logic [OFF_W-1:0]   off_q;
  logic [ENTRIES-1:0] hit_vec;
  logic [IW-1:0]      hit_idx, vic;
  logic               found;

  wire [VPN_W-1:0] vpn_in = req_addr[VA_W-1:OFF_W];
  wire [OFF_W-1:0] off_in = req_addr[OFF_W-1:0];
  wire             accept = req_valid && !walking;

  assign req_ready = !walking;
  assign mem_req   = walking;
  assign mem_addr  = base + PA_W'(vpn_q);

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) hit_vec[i] = vld[i] && (tag[i] == vpn_in);
    for (int i = ENTRIES - 1; i >= 0; i--) if (hit_vec[i]) hit_idx = IW'(i);
  end

  always_comb begin
    vic   = '0;
    found = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      if (!found && !vld[i]) begin vic = IW'(i); found = 1'b1; end
    for (int i = 0; i < ENTRIES; i++)
      if (!found && !rbit[i]) begin vic = IW'(i); found = 1'b1; end
  end

  function automatic logic [ENTRIES-1:0] touch(input logic [ENTRIES-1:0] r,
                                               input logic [ENTRIES-1:0] v,
                                               input logic [IW-1:0] k);
    logic [ENTRIES-1:0] sel, n;
    sel = ENTRIES'(1) << k;
    n   = r | sel;
    if (&(n | ~v)) n = sel;
    return n;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      vld       <= '0;
      rbit      <= '0;
      dty       <= '0;
      base      <= '0;
      walking   <= 1'b0;
      rsp_valid <= 1'b0;
      fault     <= 1'b0;
      rsp_dirty <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= 1'b0;
      fault     <= 1'b0;
      if (base_we) base <= base_wdata;
      if (accept) begin
        vpn_q <= vpn_in;
        off_q <= off_in;
        wr_q  <= req_write;
        if (|hit_vec) begin
          rbit      <= touch(rbit, vld, hit_idx);
          if (req_write) dty[hit_idx] <= 1'b1;
          rsp_valid <= 1'b1;
          rsp_paddr <= {ppn[hit_idx], off_in};
          rsp_dirty <= dty[hit_idx] | req_write;
        end else begin
          walking <= 1'b1;
        end
      end else if (walking && mem_ack) begin
        walking <= 1'b0;
        if (!mem_rdata[PV]) begin
          fault <= 1'b1;
        end else begin
          vld[vic]  <= 1'b1;
          tag[vic]  <= vpn_q;
          ppn[vic]  <= mem_rdata[PPN_W-1:0];
          dty[vic]  <= mem_rdata[PD] | wr_q;
          rbit      <= touch(rbit, vld | (ENTRIES'(1) << vic), vic);
          rsp_valid <= 1'b1;
          rsp_paddr <= {mem_rdata[PPN_W-1:0], off_q};
          rsp_dirty <= mem_rdata[PD] | wr_q;
        end
      end
    end
  end
endmodule

module addr_xlate_tlb_chk #(
  parameter int OFF_W   = 12,
  parameter int PA_W    = 32,
  parameter int ENTRIES = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               base_we,
  input logic               req_valid,
  input logic               req_ready,
  input logic [OFF_W-1:0]   req_off,
  input logic               rsp_valid,
  input logic [OFF_W-1:0]   rsp_off,
  input logic               fault,
  input logic               mem_req,
  input logic [PA_W-1:0]    mem_addr,
  input logic               mem_ack,
  input logic [ENTRIES-1:0] hit_vec
);
  logic [OFF_W-1:0] off_seen;
  always_ff @(posedge clk)
    if (rst) off_seen <= '0;
    else if (req_valid && req_ready) off_seen <= req_off;

  p_single_match_r1: assert property (@(posedge clk) disable iff (rst) $onehot0(hit_vec));
  p_rsp_source_r1: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && req_ready) || $past(mem_req && mem_ack));
  p_offset_pass_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_off == off_seen);
  p_walk_blocks_r3: assert property (@(posedge clk) disable iff (rst) mem_req |-> !req_ready);
  p_walk_hold_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack && !base_we |=> mem_req && $stable(mem_addr));
  p_fault_pulse_r5: assert property (@(posedge clk) disable iff (rst) fault |=> !fault);
  p_fault_excl_r5: assert property (@(posedge clk) disable iff (rst) !(fault && rsp_valid));
  p_reset_clean_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rsp_valid && !mem_req && !fault && req_ready);
endmodule

bind addr_xlate_tlb addr_xlate_tlb_chk #(.OFF_W(OFF_W), .PA_W(PA_W), .ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst(rst), .base_we(base_we), .req_valid(req_valid), .req_ready(req_ready),
  .req_off(req_addr[OFF_W-1:0]), .rsp_valid(rsp_valid), .rsp_off(rsp_paddr[OFF_W-1:0]),
  .fault(fault), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .hit_vec(hit_vec)
);

// File: tb/sim_addr_xlate_tlb.sv
module sim_addr_xlate_tlb;
  logic clk = 0, rst = 1;
  logic base_we = 0;
  logic [31:0] base_wdata = '0;
  logic req_valid = 0, req_write = 0;
  logic [31:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_dirty, fault, mem_req;
  logic [31:0] rsp_paddr, mem_addr;
  logic mem_ack = 0;
  logic [21:0] mem_rdata = '0;

  always #10 clk = ~clk;

  addr_xlate_tlb u0 (.*);

  typedef struct {
    bit is_fault; bit miss; logic [31:0] pa; bit dirty; logic [31:0] maddr; int acc; string rq;
  } item_t;
  item_t q[$];

  int checks = 0, fails = 0, cyc = 0, ack_cyc = 0;
  bit done = 0, saw_mem = 0;
  logic [31:0] obs_maddr;

  logic [31:0] base_m;
  bit mv[4], md[4], mr[4];
  logic [19:0] mt[4], mp[4];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%h expected=%h", rq, act, exp); end
  endtask

  task automatic finish_all();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [21:0] pt_word(input logic [31:0] idx);
    logic [19:0] p;
    p = 20'h00400 + idx[19:0] * 20'd7;
    return {(idx[3:0] != 4'hD), idx[1], p};
  endfunction

  task automatic touch_m(input int k);
    bit full;
    mr[k] = 1; full = 1;
    for (int j = 0; j < 4; j++) if (mv[j] && !mr[j]) full = 0;
    if (full) for (int j = 0; j < 4; j++) if (j != k) mr[j] = 0;
  endtask

  // model of R1, R3..R8
  task automatic access(input logic [31:0] va, input bit wr, input string rq);
    item_t it; int h; int v; logic [19:0] vpn; logic [21:0] pte;
    vpn = va[31:12]; h = -1;
    for (int i = 0; i < 4; i++) if (mv[i] && mt[i] == vpn) h = i;
    it.rq = rq; it.is_fault = 0; it.maddr = base_m + {12'b0, vpn};
    if (h >= 0) begin
      it.miss = 0; md[h] = md[h] | wr; it.dirty = md[h];
      it.pa = {mp[h], va[11:0]}; touch_m(h);
    end else begin
      it.miss = 1; pte = pt_word(it.maddr - base_m);
      if (!pte[21]) begin it.is_fault = 1; it.pa = '0; it.dirty = 0; end
      else begin
        v = -1;
        for (int i = 0; i < 4; i++) if (v < 0 && !mv[i]) v = i;
        for (int i = 0; i < 4; i++) if (v < 0 && !mr[i]) v = i;
        if (v < 0) v = 0;
        mv[v] = 1; mt[v] = vpn; mp[v] = pte[19:0]; md[v] = pte[20] | wr;
        it.dirty = md[v]; it.pa = {pte[19:0], va[11:0]}; touch_m(v);
      end
    end
    @(negedge clk); req_valid = 1; req_addr = va; req_write = wr;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1; it.acc = cyc; q.push_back(it);
    @(negedge clk); req_valid = 0;
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  task automatic load_base(input logic [31:0] b);
    @(negedge clk); base_we = 1; base_wdata = b;
    @(negedge clk); base_we = 0; base_m = b;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    for (int i = 0; i < 4; i++) begin mv[i] = 0; mr[i] = 0; md[i] = 0; end
    base_m = '0;
  endtask

  // memory responder: page table contents from pt_word
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req && !rst) begin
        repeat (1 + int'((mem_addr - base_m) % 3)) @(negedge clk);
        mem_ack = 1; mem_rdata = pt_word(mem_addr - base_m);
        @(posedge clk); #1; ack_cyc = cyc;
        @(negedge clk); mem_ack = 0;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    item_t it; int expc;
    forever begin
      @(negedge clk);
      if (mem_req) begin
        if (!saw_mem) chk(req_ready == 0, "R3 ready low during walk", 32'(req_ready), 0);
        saw_mem = 1; obs_maddr = mem_addr;
      end
      if (rsp_valid || fault) begin
        if (q.size() == 0) chk(0, "R1 unexpected result", 32'(rsp_valid), 0);
        else begin
          it = q.pop_front();
          chk(fault == it.is_fault, {it.rq, " R5 fault vs response"}, 32'(fault), 32'(it.is_fault));
          chk(saw_mem == it.miss, {it.rq, " R6 R7 hit/miss"}, 32'(saw_mem), 32'(it.miss));
          if (it.miss) chk(obs_maddr == it.maddr, {it.rq, " R3 R9 table address"}, obs_maddr, it.maddr);
          expc = it.miss ? ack_cyc : it.acc;
          chk(cyc == expc, {it.rq, " R1 R4 latency"}, 32'(cyc), 32'(expc));
          if (!it.is_fault) begin
            chk(rsp_paddr == it.pa, {it.rq, " R1 R2 R4 paddr"}, rsp_paddr, it.pa);
            chk(rsp_dirty == it.dirty, {it.rq, " R8 dirty"}, 32'(rsp_dirty), 32'(it.dirty));
          end
        end
        saw_mem = 0;
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_all();
  end

  initial begin
    logic [15:0] lf;
    base_m = '0;
    for (int i = 0; i < 4; i++) begin mv[i] = 0; mr[i] = 0; md[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !fault && !mem_req, "R10 reset state",
        {28'b0, req_ready, rsp_valid, fault, mem_req}, 32'h8);
    load_base(32'h02C7_0000);                      // R9
    access(32'h0000_2C13, 0, "R4 fill slot0");
    access(32'h0000_2ABC, 1, "R8 write hit");
    access(32'h0000_52A7, 1, "R8 write miss");
    access(32'h0000_74F5, 0, "R6 fill slot2");
    access(32'h0000_9000, 0, "R6 fill slot3");
    access(32'h0000_D123, 0, "R5 invalid entry");
    access(32'h0000_2001, 0, "R5 slot kept a");
    access(32'h0000_5FFF, 0, "R5 slot kept b");
    access(32'h0000_7000, 1, "R5 slot kept c");
    access(32'h0000_9ABC, 0, "R5 slot kept d");
    access(32'h0001_1234, 0, "R7 evict by reference");
    access(32'h0000_2777, 0, "R7 probe");
    access(32'h0000_3AAA, 0, "R6 evict next");
    lf = 16'hACE1;
    for (int n = 0; n < 60; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      access({17'b0, lf[2:0], lf[15:4]}, lf[3], "R7 stream");
    end
    load_base(32'hFFFF_FFF8);
    access(32'h0012_3456, 1, "R9 new base wrap");
    access(32'h0012_3457, 0, "R9 hit after new base");
    do_reset();
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req, "R10 ready after reset",
        {30'b0, req_ready, mem_req}, 32'h2);
    load_base(32'h0000_1000);
    access(32'h0012_3457, 0, "R10 buffer emptied");
    access(32'h0000_D000, 1, "R5 fault after reset");
    access(32'h0012_3000, 1, "R8 hit after fault");
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R1 queue drained", 32'(q.size()), 0);
    finish_all();
  end
endmodule